// File: doc/BRIEF.md
# Banked Host Register Interface with Rolling Identification

This block is the byte-wide register front end that a host processor sees on a network controller. One command register at offset 0 does two jobs, and it works the same in every bank. The top two bits of a byte written there pick one of three register banks. The low six bits carry an immediate command: start a transmit, turn receive on or off, or do a full or selective reset.

Bank 0 holds three more registers. The first is a status register with write-one-to-clear interrupt flags. The second is an interrupt mask register. The third is an identification register. Its low six bits are a fixed signature and its top two bits are a counter that steps on every read. Probing software reads this register twice and checks both the signature and the step, which makes false detection unlikely. An interrupt line is raised while any status flag is set and not masked. Offsets with no register behind them read as zero and ignore writes.

Top module: `hostreg_top`

## Requirements
- R1: A write to offset 0 loads the bank from data bits 7:6. The values 0, 1 and 2 select banks 0, 1 and 2. The value 3 leaves the bank unchanged. A read of offset 0 returns the bank in bits 7:6 and zero in bits 5:0.
- R2: A read of offset 2 in bank 0 returns 0x24 in bits 5:0, so that (value & 0x2C) == 0x24. Bits 7:6 hold a counter that is one greater on each later read, so the byte steps by 0x40 and wraps from 3 back to 0.
- R3: The identification counter changes only when offset 2 is read in bank 0. A read of offset 2 in another bank returns zero and leaves the counter alone.
- R4: Status bits are set by event inputs at these positions: bit 0 receive-stop, bit 1 receive, bit 2 transmit, bit 3 execution. A status bit stays set until a write to offset 1 in bank 0 has a one in that bit position. Writing 0x0F clears all four bits.
- R5: If an event arrives in the same cycle as a clearing write to the same bit, the bit ends up set.
- R6: Offset 3 in bank 0 is the mask register, bits 3:0, with the same bit positions as status. A one masks that source. The irq output is high while any status bit is set and its mask bit is clear.
- R7: After the reset pin: bank 0, status 0x00, mask 0x0F, identification counter 0, rxActive low, xmtStart low.
- R8: Command code 0x0E (full reset) puts every register back into the state of R7.
- R9: Command code 0x1E (selective reset) returns the bank to 0 and clears rxActive. It keeps status, mask and the identification counter.
- R10: Command code 0x04 pulses xmtStart high for one cycle. Code 0x08 sets rxActive. Codes 0x0A and 0x0B clear rxActive.
- R11: In bank 0, offsets 4 to 15 read zero and writes to them change nothing. In banks 1 and 2, every offset except 0 reads zero and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Write strobe, one cycle per byte |
| hostRd | input | 1 | Read strobe, one cycle per byte |
| hostAddr | input | 4 | Register offset |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data, valid while hostRd is high, zero otherwise |
| intEvent | input | 4 | Interrupt source events, one bit per status position |
| irq | output | 1 | Unmasked pending interrupt |
| xmtStart | output | 1 | One-cycle transmit start pulse |
| rxActive | output | 1 | Receive enabled |

## Verification
The assertions assume the host makes at most one access per cycle and never raises hostWr and hostRd together. The decode gives a write precedence, so the read strobe would otherwise be lost. The counter assertions also assume each read strobe lasts one cycle, because a held strobe counts once per cycle. The bench drives every access from one task that raises a single strobe for exactly one cycle and drops it before the next access. Event pulses coincide with a clearing write only in the one case that is deliberately testing that overlap.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 2;
  localparam int CMD_W     = DATA_W - BANK_W;
  localparam int IRQ_W     = 4;
  localparam int ID_CNT_W  = 2;
  localparam int ID_SIG_W  = DATA_W - ID_CNT_W;

  localparam logic [ID_SIG_W-1:0] ID_SIG = 6'h24;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_ID   = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_MASK = 4'd3;

  localparam logic [CMD_W-1:0] CMD_XMT     = 6'h04;
  localparam logic [CMD_W-1:0] CMD_RX_ON   = 6'h08;
  localparam logic [CMD_W-1:0] CMD_RX_OFF  = 6'h0A;
  localparam logic [CMD_W-1:0] CMD_RX_STOP = 6'h0B;
  localparam logic [CMD_W-1:0] CMD_FULLRST = 6'h0E;
  localparam logic [CMD_W-1:0] CMD_SELRST  = 6'h1E;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdId;
    logic fullReset;
    logic selReset;
    logic xmtCmd;
    logic rxOn;
    logic rxOff;
  } regStrobes_t;
endpackage

// File: rtl/hostreg_ctrl.sv
module hostreg_ctrl
  import hostreg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [BANK_W-1:0]   bank,
  output regStrobes_t         stb
);
  logic              cmdWr;
  logic              inBank0;
  logic [BANK_W-1:0] bankField;
  logic [CMD_W-1:0]  cmdCode;
  logic              bankOk;

  assign cmdWr     = hostWr && (hostAddr == OFF_CMD);
  assign inBank0   = (bank == '0);
  assign bankField = hostWdata[DATA_W-1 -: BANK_W];
  assign cmdCode   = hostWdata[CMD_W-1:0];
  assign bankOk    = (int'(bankField) < NUM_BANKS);

  always_comb begin
    stb           = '0;
    stb.wrStatus  = hostWr && inBank0 && (hostAddr == OFF_STAT);
    stb.wrMask    = hostWr && inBank0 && (hostAddr == OFF_MASK);
    stb.rdId      = hostRd && !hostWr && inBank0 && (hostAddr == OFF_ID);
    stb.fullReset = cmdWr && (cmdCode == CMD_FULLRST);
    stb.selReset  = cmdWr && (cmdCode == CMD_SELRST);
    stb.xmtCmd    = cmdWr && (cmdCode == CMD_XMT);
    stb.rxOn      = cmdWr && (cmdCode == CMD_RX_ON);
    stb.rxOff     = cmdWr && ((cmdCode == CMD_RX_OFF) || (cmdCode == CMD_RX_STOP));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bank <= '0;
    end else if (stb.fullReset || stb.selReset) begin
      bank <= '0;
    end else if (cmdWr && bankOk) begin
      bank <= bankField;
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R10

  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !bankOk && !stb.fullReset && !stb.selReset) |=> (bank == $past(bank))); // R1
endmodule

// File: rtl/hostreg_data.sv
module hostreg_data
  import hostreg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  regStrobes_t         stb,
  input  logic [BANK_W-1:0]   bank,
  input  logic                hostRd,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [IRQ_W-1:0]    wrBits,
  input  logic [IRQ_W-1:0]    intEvent,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                irq,
  output logic                xmtStart,
  output logic                rxActive
);
  localparam int PAD_W = DATA_W - IRQ_W;

  logic [IRQ_W-1:0]    status;
  logic [IRQ_W-1:0]    mask;
  logic [ID_CNT_W-1:0] idCount;

  for (genvar k = 0; k < IRQ_W; k++) begin : gStatus
    always_ff @(posedge clk) begin
      if (!rstN || stb.fullReset) begin
        status[k] <= 1'b0;
      end else if (intEvent[k]) begin
        status[k] <= 1'b1;
      end else if (stb.wrStatus && wrBits[k]) begin
        status[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.fullReset) begin
      mask     <= '1;
      idCount  <= '0;
      rxActive <= 1'b0;
      xmtStart <= 1'b0;
    end else begin
      if (stb.wrMask) mask <= wrBits;
      if (stb.rdId) idCount <= idCount + 1'b1;
      if (stb.selReset || stb.rxOff) rxActive <= 1'b0;
      else if (stb.rxOn) rxActive <= 1'b1;
      xmtStart <= stb.xmtCmd;
    end
  end

  assign irq = |(status & ~mask);

  always_comb begin
    hostRdata = '0;
    if (hostRd) begin
      if (hostAddr == OFF_CMD) begin
        hostRdata = {bank, {CMD_W{1'b0}}};
      end else if (bank == '0) begin
        case (hostAddr)
          OFF_STAT: hostRdata = {{PAD_W{1'b0}}, status};
          OFF_ID:   hostRdata = {idCount, ID_SIG};
          OFF_MASK: hostRdata = {{PAD_W{1'b0}}, mask};
          default:  hostRdata = '0;
        endcase
      end
    end
  end

  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdId |=> (idCount == $past(idCount) + 1'b1)); // R2

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rdId && !stb.fullReset) |=> (idCount == $past(idCount))); // R3

  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStatus |=> ((status & $past(wrBits & ~intEvent)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((|intEvent) && !stb.fullReset) |=> ((status & $past(intEvent)) == $past(intEvent))); // R5

  AST_FULL_RESET: assert property (@(posedge clk) disable iff (!rstN)
    stb.fullReset |=> (mask == '1 && status == '0 && idCount == '0 && !rxActive)); // R8
endmodule

// File: rtl/hostreg_top.sv
module hostreg_top
  import hostreg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [DATA_W-1:0]   hostRdata,
  input  logic [IRQ_W-1:0]    intEvent,
  output logic                irq,
  output logic                xmtStart,
  output logic                rxActive
);
  regStrobes_t       stb;
  logic [BANK_W-1:0] bank;

  hostreg_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .bank      (bank),
    .stb       (stb)
  );

  hostreg_data uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .bank      (bank),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .wrBits    (hostWdata[IRQ_W-1:0]),
    .intEvent  (intEvent),
    .hostRdata (hostRdata),
    .irq       (irq),
    .xmtStart  (xmtStart),
    .rxActive  (rxActive)
  );
endmodule

// File: tb/tb_hostreg_top.sv
module tb_hostreg_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [3:0] intEvent = '0;
  logic       irq;
  logic       xmtStart;
  logic       rxActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hostreg_top dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .intEvent(intEvent), .irq(irq), .xmtStart(xmtStart), .rxActive(rxActive)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: one read strobe, expected value goes to the scoreboard
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [3:0] ev = 4'h0);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d; intEvent = ev;
    @(negedge clk);
    hostWr = 1'b0; intEvent = '0;
  endtask

  task automatic pulseEv(input logic [3:0] ev);
    @(negedge clk);
    intEvent = ev;
    @(negedge clk);
    intEvent = '0;
  endtask

  // monitor: compares each read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (hostRd) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard empty actual=%02h expected=none", hostRdata);
        end else begin
          check(tagQ.pop_front(), hostRdata, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R7 reset state
    rd(4'd0, 8'h00, "R7 bank");
    rd(4'd1, 8'h00, "R7 status");
    rd(4'd3, 8'h0F, "R7 mask");
    check("R7 irq", {7'b0, irq}, 8'h00);
    check("R7 rxActive", {7'b0, rxActive}, 8'h00);
    check("R7 xmtStart", {7'b0, xmtStart}, 8'h00);

    // R2 signature and rolling counter with wrap
    rd(4'd2, 8'h24, "R2 id0");
    rd(4'd2, 8'h64, "R2 id1");
    rd(4'd2, 8'hA4, "R2 id2");
    rd(4'd2, 8'hE4, "R2 id3");
    rd(4'd2, 8'h24, "R2 wrap");

    // R1 / R3 / R11 other banks
    wr(4'd0, 8'h40);
    rd(4'd0, 8'h40, "R1 bank1");
    rd(4'd2, 8'h00, "R3 id bank1");
    wr(4'd3, 8'h00);
    rd(4'd3, 8'h00, "R11 bank1 off3");
    wr(4'd0, 8'h80);
    rd(4'd0, 8'h80, "R1 bank2");
    wr(4'd0, 8'hC0);
    rd(4'd0, 8'h80, "R1 bank3 ignored");
    wr(4'd0, 8'h00);
    rd(4'd2, 8'h64, "R3 no advance");
    rd(4'd3, 8'h0F, "R11 mask unchanged");
    wr(4'd5, 8'hFF);
    rd(4'd5, 8'h00, "R11 off5");

    // R4 / R6 status and mask
    pulseEv(4'b0110);
    rd(4'd1, 8'h06, "R4 status set");
    check("R6 irq masked", {7'b0, irq}, 8'h00);
    wr(4'd3, 8'h09);
    rd(4'd3, 8'h09, "R6 mask write");
    check("R6 irq unmasked", {7'b0, irq}, 8'h01);
    wr(4'd1, 8'h02);
    rd(4'd1, 8'h04, "R4 w1c rx");
    check("R6 irq tx pending", {7'b0, irq}, 8'h01);
    wr(4'd1, 8'h0F);
    rd(4'd1, 8'h00, "R4 w1c all");
    check("R6 irq clear", {7'b0, irq}, 8'h00);

    // R5 set beats clear
    wr(4'd1, 8'h08, 4'b1000);
    rd(4'd1, 8'h08, "R5 set wins");

    // R10 commands
    wr(4'd0, 8'h04);
    check("R10 xmt pulse", {7'b0, xmtStart}, 8'h01);
    @(negedge clk);
    check("R10 xmt one cycle", {7'b0, xmtStart}, 8'h00);
    wr(4'd0, 8'h08);
    check("R10 rx on", {7'b0, rxActive}, 8'h01);
    wr(4'd0, 8'h0B);
    check("R10 rx stop", {7'b0, rxActive}, 8'h00);
    wr(4'd0, 8'h08);
    wr(4'd0, 8'h0A);
    check("R10 rx off", {7'b0, rxActive}, 8'h00);

    // R9 selective reset
    wr(4'd0, 8'h08);
    wr(4'd0, 8'h80);
    wr(4'd0, 8'h1E);
    check("R9 rxActive", {7'b0, rxActive}, 8'h00);
    rd(4'd0, 8'h00, "R9 bank");
    rd(4'd1, 8'h08, "R9 status kept");
    rd(4'd3, 8'h09, "R9 mask kept");
    rd(4'd2, 8'hA4, "R9 id kept");

    // R8 full reset
    wr(4'd0, 8'h08);
    wr(4'd0, 8'h0E);
    check("R8 rxActive", {7'b0, rxActive}, 8'h00);
    check("R8 irq", {7'b0, irq}, 8'h00);
    rd(4'd1, 8'h00, "R8 status");
    rd(4'd3, 8'h0F, "R8 mask");
    rd(4'd2, 8'h24, "R8 id");

    @(negedge clk);
    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule